// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor and decides whether a new thread block may become resident there. Each request carries a thread count, a register count per thread and a shared-memory size in bytes. The controller checks four budgets in the same cycle: free block slots, free thread capacity, free register-file entries (thread count times per-thread registers) and free shared-memory bytes. A block is admitted whole or not at all. When it fits, the controller reserves every resource it asked for, records them against the lowest free slot and returns that slot's number and the block's warp count.

When a resident block finishes, its slot number is presented on the completion port. The controller returns all of that block's resources to the free pools. A release and a new request may arrive in the same cycle. The release always takes effect first, so the request can use what was just freed, including the freed slot.

Requests use a valid/ready handshake. `req_ready` is low while reset is asserted and in the first cycle after it, then stays high, so a request is taken on every cycle in which `req_valid` is high. Each accepted request yields exactly one response on the next cycle. The response side has no ready and cannot be stalled. The completion port and the free-resource outputs are plain signals.

Top module: `blk_admit_ctrl`

## Requirements
- R1: A request whose thread count is 0 or greater than 512 gets a response with `resp_error`=1 and `resp_grant`=0, and it reserves nothing.
- R2: At most 8 blocks are resident. While all 8 slots are busy, any request is refused (`resp_grant`=0, `resp_error`=0), even if every other budget has room.
- R3: Resident threads never exceed 768. A request is refused if its thread count is larger than 768 minus the threads already resident.
- R4: The register file holds 8192 entries. A request is refused if thread count times per-thread registers is larger than the entries still free. An exact fit is granted.
- R5: Shared memory is 16384 bytes. A request is refused if its byte count is larger than the bytes still free. An exact fit is granted.
- R6: A grant returns on `resp_slot` the lowest-numbered free slot as a 3-bit binary index, and `slot_busy` bit n is 1 exactly while slot n holds a block.
- R7: On a grant, `resp_warps` equals the thread count divided by 32, rounded up.
- R8: A completion for a busy slot returns all of that block's threads, registers, shared memory and its slot to the free pools, as seen on `free_threads`, `free_regs`, `free_smem` and `slot_busy` one cycle later. A completion for a slot that is already free changes nothing.
- R9: When a completion and a request arrive in the same cycle, the release is applied first, and the request is judged against the pools after the release.
- R10: After reset, all budgets read fully free (768, 8192, 16384), `slot_busy` is 0, `resp_valid` is 0 and `req_ready` is 0 while reset is held.
- R11: A request is taken only when `req_valid` and `req_ready` are both 1. Exactly one response follows, with `resp_valid`=1 on the next cycle, and `resp_valid` is 0 in any cycle after which no request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_threads | input | 10 | Threads in the block |
| req_regs_per_thr | input | 8 | Registers needed by each thread |
| req_smem | input | 16 | Shared-memory bytes needed by the block |
| cpl_valid | input | 1 | Completion present |
| cpl_slot | input | 3 | Slot whose block has finished |
| resp_valid | output | 1 | Response for the request taken last cycle |
| resp_grant | output | 1 | Block admitted |
| resp_error | output | 1 | Thread count out of range |
| resp_slot | output | 3 | Slot given to an admitted block |
| resp_warps | output | 5 | Warp count of an admitted block |
| free_threads | output | 10 | Thread capacity still free |
| free_regs | output | 14 | Register-file entries still free |
| free_smem | output | 15 | Shared-memory bytes still free |
| slot_busy | output | 8 | One bit per slot, 1 when occupied |

## Verification
The hardest case to reach from the ports is a request that fits only because of a release in the same cycle. It needs the pools filled to exact capacity first, so that one budget is fully used, and then a completion and a request presented together. The stimulus table sets up that case: three 256-thread blocks use all 768 threads and all 8192 registers, and then a completion for the middle slot is presented together with a new request. The expected response is a grant of that just-freed slot. The same table takes each other budget to an exact fit and one unit past it, and it fills all eight slots while the other budgets still have room, so that only the slot limit refuses the request.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  localparam int unsigned DEF_SLOTS       = 8;
  localparam int unsigned DEF_SM_THREADS  = 768;
  localparam int unsigned DEF_BLK_THREADS = 512;
  localparam int unsigned DEF_RF_ENTRIES  = 8192;
  localparam int unsigned DEF_SMEM_BYTES  = 16384;
  localparam int unsigned DEF_WARP_SIZE   = 32;
  localparam int unsigned DEF_THR_W       = 10;
  localparam int unsigned DEF_RPT_W       = 8;
  localparam int unsigned DEF_SMEM_REQ_W  = 16;

  typedef enum logic [1:0] {
    OUT_NONE   = 2'd0,
    OUT_GRANT  = 2'd1,
    OUT_REFUSE = 2'd2,
    OUT_ERROR  = 2'd3
  } outcome_e;
endpackage

// File: rtl/slot_finder.sv
module slot_finder #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  free_mask,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [N:0]   lower_any;
  logic [N-1:0] pick;

  assign lower_any[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign pick[i]        = free_mask[i] & ~lower_any[i];
    assign lower_any[i+1] = lower_any[i] | free_mask[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pick[i]) idx = idx | IW'(i);
    end
  end

  assign found = lower_any[N];

  always_comb begin
    a_r6_pick_single : assert ($onehot0(pick));
  end
endmodule

// File: rtl/budget_pool.sv
module budget_pool #(
  parameter int unsigned CAP = 768,
  parameter int unsigned W   = $clog2(CAP + 1),
  parameter int unsigned RW  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rel_en,
  input  logic [W-1:0]  rel_amt,
  input  logic [RW-1:0] req_amt,
  input  logic          take_en,
  output logic          fit,
  output logic [W-1:0]  free_now
);
  localparam int unsigned CW = (RW > W) ? RW : W;

  logic [W-1:0] used_q;
  logic [W-1:0] used_after_rel;
  logic [W-1:0] free_after_rel;
  logic [W-1:0] used_d;

  assign used_after_rel = rel_en ? (used_q - rel_amt) : used_q;
  assign free_after_rel = W'(CAP) - used_after_rel;
  assign fit            = (CW'(req_amt) <= CW'(free_after_rel));
  assign used_d         = take_en ? (used_after_rel + W'(req_amt)) : used_after_rel;
  assign free_now       = W'(CAP) - used_q;

  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else     used_q <= used_d;
  end

  // R3, R4, R5: a pool never holds more than its capacity
  a_r3_pool_within_cap : assert property (@(posedge clk) disable iff (rst)
    used_q <= W'(CAP));

  a_r8_release_not_above_used : assert property (@(posedge clk) disable iff (rst)
    rel_en |-> rel_amt <= used_q);
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl
  import blk_admit_pkg::*;
#(
  parameter int unsigned SLOTS       = DEF_SLOTS,
  parameter int unsigned SM_THREADS  = DEF_SM_THREADS,
  parameter int unsigned BLK_THREADS = DEF_BLK_THREADS,
  parameter int unsigned RF_ENTRIES  = DEF_RF_ENTRIES,
  parameter int unsigned SMEM_BYTES  = DEF_SMEM_BYTES,
  parameter int unsigned WARP_SIZE   = DEF_WARP_SIZE,
  parameter int unsigned THR_W       = DEF_THR_W,
  parameter int unsigned RPT_W       = DEF_RPT_W,
  parameter int unsigned SMEM_REQ_W  = DEF_SMEM_REQ_W,
  parameter int unsigned SLOT_W      = $clog2(SLOTS),
  parameter int unsigned WARP_W      = $clog2(BLK_THREADS / WARP_SIZE) + 1,
  parameter int unsigned FT_W        = $clog2(SM_THREADS + 1),
  parameter int unsigned FR_W        = $clog2(RF_ENTRIES + 1),
  parameter int unsigned FS_W        = $clog2(SMEM_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [THR_W-1:0]      req_threads,
  input  logic [RPT_W-1:0]      req_regs_per_thr,
  input  logic [SMEM_REQ_W-1:0] req_smem,
  input  logic                  cpl_valid,
  input  logic [SLOT_W-1:0]     cpl_slot,
  output logic                  resp_valid,
  output logic                  resp_grant,
  output logic                  resp_error,
  output logic [SLOT_W-1:0]     resp_slot,
  output logic [WARP_W-1:0]     resp_warps,
  output logic [FT_W-1:0]       free_threads,
  output logic [FR_W-1:0]       free_regs,
  output logic [FS_W-1:0]       free_smem,
  output logic [SLOTS-1:0]      slot_busy
);
  localparam int unsigned NEED_W = THR_W + RPT_W;
  localparam int unsigned WSH    = $clog2(WARP_SIZE);

  // per-slot reservation records
  logic [FT_W-1:0] rec_thr  [SLOTS];
  logic [FR_W-1:0] rec_regs [SLOTS];
  logic [FS_W-1:0] rec_smem [SLOTS];
  logic [SLOTS-1:0] busy_q;
  logic             ready_q;

  logic              accept;
  logic              rel_en;
  logic [SLOTS-1:0]  rel_mask;
  logic [SLOTS-1:0]  busy_after_rel;
  logic              slot_found;
  logic [SLOT_W-1:0] slot_idx;
  logic              range_ok;
  logic [NEED_W-1:0] regs_need;
  logic [THR_W:0]    warp_sum;
  logic [WARP_W-1:0] warps_calc;
  logic              fit_thr, fit_regs, fit_smem;
  logic              grant;
  outcome_e          outcome;

  assign accept    = req_valid & req_ready;
  assign req_ready = ready_q;

  // release side: applied before the grant decision
  assign rel_en = cpl_valid & busy_q[cpl_slot];

  for (genvar s = 0; s < SLOTS; s++) begin : g_relmask
    assign rel_mask[s] = rel_en & (cpl_slot == SLOT_W'(s));
  end

  assign busy_after_rel = busy_q & ~rel_mask;

  slot_finder #(.N(SLOTS), .IW(SLOT_W)) u_slot_finder (
    .free_mask (~busy_after_rel),
    .found     (slot_found),
    .idx       (slot_idx)
  );

  // request decode
  assign range_ok   = (req_threads != '0) && (32'(req_threads) <= BLK_THREADS);
  assign regs_need  = {{RPT_W{1'b0}}, req_threads} * {{THR_W{1'b0}}, req_regs_per_thr};
  assign warp_sum   = {1'b0, req_threads} + (THR_W+1)'(WARP_SIZE - 1);
  assign warps_calc = WARP_W'(warp_sum >> WSH);

  budget_pool #(.CAP(SM_THREADS), .W(FT_W), .RW(THR_W)) u_pool_thr (
    .clk      (clk),
    .rst      (rst),
    .rel_en   (rel_en),
    .rel_amt  (rec_thr[cpl_slot]),
    .req_amt  (req_threads),
    .take_en  (grant),
    .fit      (fit_thr),
    .free_now (free_threads)
  );

  budget_pool #(.CAP(RF_ENTRIES), .W(FR_W), .RW(NEED_W)) u_pool_regs (
    .clk      (clk),
    .rst      (rst),
    .rel_en   (rel_en),
    .rel_amt  (rec_regs[cpl_slot]),
    .req_amt  (regs_need),
    .take_en  (grant),
    .fit      (fit_regs),
    .free_now (free_regs)
  );

  budget_pool #(.CAP(SMEM_BYTES), .W(FS_W), .RW(SMEM_REQ_W)) u_pool_smem (
    .clk      (clk),
    .rst      (rst),
    .rel_en   (rel_en),
    .rel_amt  (rec_smem[cpl_slot]),
    .req_amt  (req_smem),
    .take_en  (grant),
    .fit      (fit_smem),
    .free_now (free_smem)
  );

  always_comb begin
    if (!accept)                                            outcome = OUT_NONE;
    else if (!range_ok)                                     outcome = OUT_ERROR;
    else if (slot_found && fit_thr && fit_regs && fit_smem) outcome = OUT_GRANT;
    else                                                    outcome = OUT_REFUSE;
  end

  assign grant = (outcome == OUT_GRANT);

  // slot state and records
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= '0;
      ready_q <= 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        rec_thr[s]  <= '0;
        rec_regs[s] <= '0;
        rec_smem[s] <= '0;
      end
    end else begin
      ready_q <= 1'b1;
      busy_q  <= busy_after_rel;
      if (grant) begin
        busy_q[slot_idx]   <= 1'b1;
        rec_thr[slot_idx]  <= FT_W'(req_threads);
        rec_regs[slot_idx] <= FR_W'(regs_need);
        rec_smem[slot_idx] <= FS_W'(req_smem);
      end
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
      resp_error <= 1'b0;
      resp_slot  <= '0;
      resp_warps <= '0;
    end else begin
      resp_valid <= (outcome != OUT_NONE);
      resp_grant <= (outcome == OUT_GRANT);
      resp_error <= (outcome == OUT_ERROR);
      resp_slot  <= grant ? slot_idx : '0;
      resp_warps <= (outcome == OUT_ERROR) ? '0 : warps_calc;
    end
  end

  assign slot_busy = busy_q;

  // assertions
  a_r11_resp_after_accept : assert property (@(posedge clk) disable iff (rst)
    accept |=> resp_valid);

  a_r11_no_resp_without_accept : assert property (@(posedge clk) disable iff (rst)
    !accept |=> !resp_valid);

  a_r1_bad_count_errors : assert property (@(posedge clk) disable iff (rst)
    (accept && (req_threads == '0)) |=> (resp_error && !resp_grant));

  a_r6_granted_slot_busy : assert property (@(posedge clk) disable iff (rst)
    resp_grant |-> slot_busy[resp_slot]);

  a_r7_warps_in_range : assert property (@(posedge clk) disable iff (rst)
    resp_grant |-> (resp_warps != '0 && 32'(resp_warps) <= BLK_THREADS / WARP_SIZE));

  a_r8_release_frees_threads : assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && slot_busy[cpl_slot] && !accept) |=> free_threads > $past(free_threads));

  a_r2_full_refuses : assert property (@(posedge clk) disable iff (rst)
    (accept && (&slot_busy) && !cpl_valid) |=> !resp_grant);
endmodule

// File: tb/test_blk_admit_ctrl.sv
module test_blk_admit_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [9:0]  req_threads;
  logic [7:0]  req_regs_per_thr;
  logic [15:0] req_smem;
  logic        cpl_valid;
  logic [2:0]  cpl_slot;
  logic        resp_valid, resp_grant, resp_error;
  logic [2:0]  resp_slot;
  logic [4:0]  resp_warps;
  logic [9:0]  free_threads;
  logic [13:0] free_regs;
  logic [14:0] free_smem;
  logic [7:0]  slot_busy;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10ns clk = ~clk;

  blk_admit_ctrl i_blk_admit_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_regs_per_thr(req_regs_per_thr), .req_smem(req_smem),
    .cpl_valid(cpl_valid), .cpl_slot(cpl_slot),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_error(resp_error),
    .resp_slot(resp_slot), .resp_warps(resp_warps),
    .free_threads(free_threads), .free_regs(free_regs), .free_smem(free_smem),
    .slot_busy(slot_busy)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic       rv;
    logic [9:0] thr;
    logic [7:0] rpt;
    logic [15:0] sm;
    logic       cv;
    logic [2:0] cs;
    logic       eg;
    logic       ee;
    logic [2:0] es;
    logic [4:0] ew;
    logic [9:0] eft;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 10'd0,   8'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 5'd0, 10'd768}, // R1 zero
    '{1'b1, 10'd513, 8'd1,  16'd0,    1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 5'd0, 10'd768}, // R1 too many
    '{1'b1, 10'd256, 8'd10, 16'd4096, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 5'd8, 10'd512}, // R6 R7
    '{1'b1, 10'd256, 8'd10, 16'd4096, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1, 5'd8, 10'd256},
    '{1'b1, 10'd256, 8'd13, 16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 5'd8, 10'd256}, // R4 over
    '{1'b1, 10'd256, 8'd12, 16'd4096, 1'b0, 3'd0, 1'b1, 1'b0, 3'd2, 5'd8, 10'd0},   // R4 R3 exact
    '{1'b1, 10'd1,   8'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 5'd1, 10'd0},   // R3 over
    '{1'b1, 10'd33,  8'd1,  16'd0,    1'b1, 3'd1, 1'b1, 1'b0, 3'd1, 5'd2, 10'd223}, // R9
    '{1'b1, 10'd1,   8'd0,  16'd8193, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 5'd1, 10'd223}, // R5 over
    '{1'b1, 10'd1,   8'd0,  16'd8192, 1'b0, 3'd0, 1'b1, 1'b0, 3'd3, 5'd1, 10'd222}, // R5 exact
    '{1'b1, 10'd1,   8'd0,  16'd1,    1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 5'd1, 10'd222}, // R5 empty
    '{1'b0, 10'd0,   8'd0,  16'd0,    1'b1, 3'd7, 1'b0, 1'b0, 3'd0, 5'd0, 10'd222}, // R8 free slot, R11
    '{1'b1, 10'd1,   8'd0,  16'd0,    1'b0, 3'd0, 1'b1, 1'b0, 3'd4, 5'd1, 10'd221},
    '{1'b1, 10'd1,   8'd0,  16'd0,    1'b0, 3'd0, 1'b1, 1'b0, 3'd5, 5'd1, 10'd220},
    '{1'b1, 10'd1,   8'd0,  16'd0,    1'b0, 3'd0, 1'b1, 1'b0, 3'd6, 5'd1, 10'd219},
    '{1'b1, 10'd1,   8'd0,  16'd0,    1'b0, 3'd0, 1'b1, 1'b0, 3'd7, 5'd1, 10'd218},
    '{1'b1, 10'd1,   8'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 5'd1, 10'd218}  // R2 full
  };

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_threads = '0; req_regs_per_thr = '0; req_smem = '0;
    cpl_valid = 1'b0; cpl_slot = '0;
    repeat (3) @(negedge clk);
    check("R10 ready low in reset", int'(req_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 resp_valid", int'(resp_valid), 0);
    check("R10 free_threads", int'(free_threads), 768);
    check("R10 free_regs", int'(free_regs), 8192);
    check("R10 free_smem", int'(free_smem), 16384);
    check("R10 slot_busy", int'(slot_busy), 0);
    check("R11 ready after reset", int'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      req_valid        = TBL[i].rv;
      req_threads      = TBL[i].thr;
      req_regs_per_thr = TBL[i].rpt;
      req_smem         = TBL[i].sm;
      cpl_valid        = TBL[i].cv;
      cpl_slot         = TBL[i].cs;
      @(negedge clk);
      req_valid = 1'b0; cpl_valid = 1'b0;
      check($sformatf("R11 step %0d resp_valid", i), int'(resp_valid), int'(TBL[i].rv));
      if (TBL[i].rv) begin
        check($sformatf("R1-R5 step %0d grant", i), int'(resp_grant), int'(TBL[i].eg));
        check($sformatf("R1 step %0d error", i), int'(resp_error), int'(TBL[i].ee));
        if (TBL[i].eg) begin
          check($sformatf("R6 step %0d slot", i), int'(resp_slot), int'(TBL[i].es));
          check($sformatf("R7 step %0d warps", i), int'(resp_warps), int'(TBL[i].ew));
        end
      end
      check($sformatf("R3 step %0d free_threads", i), int'(free_threads), int'(TBL[i].eft));
    end

    check("R2 all slots busy", int'(slot_busy), 255);
    check("R5 smem used up", int'(free_smem), 0);

    // R8: release every slot, one per cycle
    for (int s = 0; s < 8; s++) begin
      cpl_valid = 1'b1;
      cpl_slot  = 3'(s);
      @(negedge clk);
    end
    cpl_valid = 1'b0;
    @(negedge clk);
    check("R8 free_threads restored", int'(free_threads), 768);
    check("R8 free_regs restored", int'(free_regs), 8192);
    check("R8 free_smem restored", int'(free_smem), 16384);
    check("R8 slots released", int'(slot_busy), 0);

    // R7 corner: 32 threads is one warp, 512 threads is sixteen
    req_valid = 1'b1; req_threads = 10'd32; req_regs_per_thr = 8'd1; req_smem = 16'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 32 threads warps", int'(resp_warps), 1);
    check("R6 lowest slot after drain", int'(resp_slot), 0);
    req_valid = 1'b1; req_threads = 10'd512; req_regs_per_thr = 8'd1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 512 accepted", int'(resp_grant), 1);
    check("R7 512 threads warps", int'(resp_warps), 16);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule